// File: doc/BRIEF.md
# Multi-Mode Programmable Counter Channel

This block is one 16-bit down-counting channel of an interval timer. A count-enable tick advances it, a gate input qualifies or retriggers it, and a single output carries the waveform of the selected mode. The register interface outside the block writes a mode and number-format setting with a configuration strobe. It writes an initial value with a load strobe. The block shows its current count and output level so that a surrounding latch can capture them.

Six modes are available: two one-shot outputs, two strobe outputs, a periodic rate pulse and a square wave. Each mode is started either by software (a load) or by hardware (a gate rising edge). The count runs in plain binary or in four-digit decimal (BCD). A loaded value of zero stands for the largest period: 65536 in binary, 10000 in BCD. The gate edge detector keeps the gate level of the previous cycle. That level resets high when the CHAN_IDX parameter is 0 or 1 and low for any other index.

Below, N is the numeric value of the last load (the full period when zero was loaded). d is the number of counted ticks since counting last started.

Top module: `pit_channel`

## Requirements
- R1: After reset the count reads 0x0000, which stands for the full period, and the output is low. The channel is disabled until its first configuration write. While disabled, a load stores its value on the count, ticks do not change the count, and the output stays low.
- R2: A configuration write sets the mode from cfg_mode and the format from cfg_bcd (1 = BCD) and stops counting until the next load. Codes 0 to 5 select modes 0 to 5, code 6 selects mode 2 and code 7 selects mode 3. The output goes to the idle level of the new mode: high for modes 1 and 3, low for the others.
- R3: On a load the count shows load_value in the next cycle, d restarts at 0, and the output takes the mode's idle level. A value of zero gives N = 65536 in binary or 10000 in BCD. A load in the same cycle as a tick or a gate rising edge wins, and the tick is not counted. A configuration write and a load in the same cycle start counting in the newly written mode.
- R4: A tick is counted only in a cycle where tick is high. In modes 0, 2, 3 and 4 the gate must also be high in that cycle, otherwise counting is suspended. In modes 1 and 5 the gate level has no effect.
- R5: While counting in modes 1, 2, 3 and 5, a gate rising edge (gate high, low in the previous cycle) restarts the channel: the count returns to N, d becomes 0 and the output returns to its idle level. This restart wins over a tick in the same cycle. In modes 0 and 4 a rising edge does not restart the channel.
- R6: In modes 0, 1, 4 and 5 the count reads (N - d) modulo the full period. It steps down by one per counted tick and wraps from 0 to 0xFFFF in binary or 0x9999 in BCD.
- R7: In mode 0 the output rises when d reaches N and then stays high. In mode 1 the output is high while d < N and stays low afterwards.
- R8: In mode 2 the count reads N - (d mod N), reloading instead of reaching zero. The output is high exactly while d is a nonzero multiple of N, so it is one tick long and is not asserted at the start.
- R9: In mode 3 the count reads N - (2d mod N), so it steps by two. The output is high while (d mod N) < (N+1)/2 and low for the rest of each period.
- R10: In modes 4 and 5 the output is high only while d equals N, and it does not repeat after the count wraps.
- R11: In BCD format each 4-bit digit counts down decimally from 9 to 0 and borrows from the next digit, so for example 0x0100 is followed by 0x0099 and 0x0000 by 0x9999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable tick, one per counted step |
| gate | input | 1 | Gate level; qualifies counting or retriggers by mode |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode code written with cfg_wr |
| cfg_bcd | input | 1 | Number format written with cfg_wr (1 = BCD) |
| load | input | 1 | Initial value load strobe |
| load_value | input | 16 | Initial value; zero means full period |
| count | output | 16 | Current count |
| out | output | 1 | Mode waveform output |

## Verification
Several of this block's actions can fall in the same clock cycle. A counted tick can meet a load, a counted tick can meet a gate rising edge, and a configuration write can meet a load. The bench provokes each pairing by raising both strobes, or the tick together with a gate edge, in a single driven cycle. It judges the result against a behavioural model that applies the stated priority and tracks elapsed ticks rather than a counter. In that model the winning action restarts d at zero, and the losing tick never appears in the expected count or output.

// File: rtl/pit_channel_pkg.sv
`timescale 1ns/1ps
package pit_channel_pkg;

    typedef enum logic [2:0] {
        MODE_TERM_SW   = 3'd0,
        MODE_ONESHOT   = 3'd1,
        MODE_RATE      = 3'd2,
        MODE_SQUARE    = 3'd3,
        MODE_STROBE_SW = 3'd4,
        MODE_STROBE_HW = 3'd5
    } chan_mode_e;

    // Codes 6 and 7 alias the two periodic modes.
    function automatic chan_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd6:    return MODE_RATE;
            3'd7:    return MODE_SQUARE;
            default: return chan_mode_e'(code);
        endcase
    endfunction

    function automatic logic idle_level(input chan_mode_e m);
        return (m == MODE_ONESHOT) || (m == MODE_SQUARE);
    endfunction

    function automatic logic gate_qualifies(input chan_mode_e m);
        return (m != MODE_ONESHOT) && (m != MODE_STROBE_HW);
    endfunction

    function automatic logic edge_restarts(input chan_mode_e m);
        return (m == MODE_ONESHOT) || (m == MODE_RATE) ||
               (m == MODE_SQUARE)  || (m == MODE_STROBE_HW);
    endfunction

endpackage

// File: rtl/pit_dec.sv
`timescale 1ns/1ps
module pit_dec #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         bcd,
    output logic [W-1:0] res
);
    localparam int DIGITS = W / 4;
    localparam logic [W-1:0] UNIT = W'(1);

    logic [W-1:0] bcd_res;
    logic         borrow;
    logic [3:0]   nib;

    always_comb begin
        borrow  = 1'b1;
        bcd_res = '0;
        nib     = '0;
        for (int i = 0; i < DIGITS; i++) begin
            nib = val[i*4 +: 4];
            if (!borrow)
                bcd_res[i*4 +: 4] = nib;
            else if (nib == 4'd0)
                bcd_res[i*4 +: 4] = 4'd9;
            else
                bcd_res[i*4 +: 4] = nib - 4'd1;
            borrow = borrow && (nib == 4'd0);
        end
    end

    assign res = bcd ? bcd_res : (val - UNIT);

endmodule

// File: rtl/pit_gate_edge.sv
`timescale 1ns/1ps
module pit_gate_edge #(
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = gate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_LEVEL;
        else        prev_q <= prev_d;
    end

    assign rise = gate && !prev_q;

endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
    import pit_channel_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int CHAN_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_bcd,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    output logic [CNT_W-1:0] count,
    output logic             out
);
    localparam logic GATE_RST = (CHAN_IDX == 0) || (CHAN_IDX == 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    typedef struct packed {
        chan_mode_e       mode;
        logic             bcd;
        logic             enabled;
        logic             running;
        logic             done;
        logic             out;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] init;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_m1, cnt_m2, init_m1;
    logic gate_rise, tick_ok;

    pit_dec #(.W(CNT_W)) u_dec_one (.val(st_q.cnt),  .bcd(st_q.bcd), .res(cnt_m1));
    pit_dec #(.W(CNT_W)) u_dec_two (.val(cnt_m1),    .bcd(st_q.bcd), .res(cnt_m2));
    pit_dec #(.W(CNT_W)) u_dec_ini (.val(st_q.init), .bcd(st_q.bcd), .res(init_m1));

    pit_gate_edge #(.RST_LEVEL(GATE_RST)) u_gate (
        .clk(clk), .rst_n(rst_n), .gate(gate), .rise(gate_rise)
    );

    assign tick_ok = tick && (gate || !gate_qualifies(st_q.mode));

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.mode    = decode_mode(cfg_mode);
            st_d.bcd     = cfg_bcd;
            st_d.enabled = 1'b1;
            st_d.running = 1'b0;
            st_d.done    = 1'b0;
            st_d.out     = idle_level(decode_mode(cfg_mode));
        end
        if (load) begin
            st_d.init    = load_value;
            st_d.cnt     = load_value;
            st_d.done    = 1'b0;
            st_d.running = st_d.enabled;
            st_d.out     = st_d.enabled && idle_level(st_d.mode);
        end else if (st_q.running && !cfg_wr && gate_rise && edge_restarts(st_q.mode)) begin
            st_d.cnt  = st_q.init;
            st_d.done = 1'b0;
            st_d.out  = idle_level(st_q.mode);
        end else if (st_q.running && !cfg_wr && tick_ok) begin
            case (st_q.mode)
                MODE_TERM_SW: begin
                    st_d.cnt = cnt_m1;
                    if (st_q.cnt == ONE) st_d.out = 1'b1;
                end
                MODE_ONESHOT: begin
                    st_d.cnt = cnt_m1;
                    if (st_q.cnt == ONE) st_d.out = 1'b0;
                end
                MODE_RATE: begin
                    if (st_q.cnt == ONE) begin
                        st_d.cnt = st_q.init;
                        st_d.out = 1'b1;
                    end else begin
                        st_d.cnt = cnt_m1;
                        st_d.out = 1'b0;
                    end
                end
                MODE_SQUARE: begin
                    if (st_q.init == ONE) begin
                        st_d.cnt = st_q.cnt;
                    end else if (st_q.cnt == TWO) begin
                        st_d.cnt = st_q.init;
                        st_d.out = !st_q.out;
                    end else if (st_q.cnt == ONE) begin
                        st_d.cnt = init_m1;
                        st_d.out = !st_q.out;
                    end else begin
                        st_d.cnt = cnt_m2;
                    end
                end
                MODE_STROBE_SW, MODE_STROBE_HW: begin
                    st_d.cnt = cnt_m1;
                    if (st_q.cnt == ONE && !st_q.done) begin
                        st_d.out  = 1'b1;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.out = 1'b0;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode    <= MODE_TERM_SW;
            st_q.bcd     <= 1'b0;
            st_q.enabled <= 1'b0;
            st_q.running <= 1'b0;
            st_q.done    <= 1'b0;
            st_q.out     <= 1'b0;
            st_q.cnt     <= '0;
            st_q.init    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign out   = st_q.out;

endmodule

// File: rtl/pit_channel_chk.sv
`timescale 1ns/1ps
module pit_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             gate,
    input logic             load,
    input logic             cfg_wr,
    input logic [CNT_W-1:0] load_value,
    input logic [CNT_W-1:0] count,
    input logic             out,
    input logic             gate_rise,
    input logic [2:0]       mode,
    input logic             running,
    input logic             enabled,
    input logic [CNT_W-1:0] init
);
    assert_load_shows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_value));

    assert_term_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mode == 3'd0 && out && !load && !cfg_wr) |=> out);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !cfg_wr && !gate_rise) |=> ($stable(count) && $stable(out)));

    assert_rate_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mode == 3'd2 && out) |-> count == init);

    assert_disabled_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> !out);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (mode == 3'd4 || mode == 3'd5) && out && tick &&
         (gate || mode == 3'd5) && !load && !cfg_wr && !gate_rise) |=> !out);
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
    .cfg_wr(cfg_wr), .load_value(load_value), .count(count), .out(out),
    .gate_rise(gate_rise), .mode(st_q.mode), .running(st_q.running),
    .enabled(st_q.enabled), .init(st_q.init)
);

// File: tb/pit_channel_tb.sv
`timescale 1ns/1ps
module pit_channel_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, tick = 1'b0, gate = 1'b0, cfg_wr = 1'b0, cfg_bcd = 1'b0, load = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic [15:0] load_value = 16'd0;
    logic [15:0] count;
    logic        out;

    pit_channel #(.CNT_W(16), .CHAN_IDX(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .cfg_wr(cfg_wr),
        .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd), .load(load),
        .load_value(load_value), .count(count), .out(out)
    );

    int n_cmp = 0, n_bad = 0, cycles = 0;
    string phase = "R1";
    bit finished = 0;

    // Behavioural model in elapsed-tick terms
    int m_mode = 0, m_bcd = 0, m_en = 0, m_run = 0, m_N = 65536, m_d = 0, m_prev = 0;
    logic [15:0] m_disp = 16'd0;
    logic        m_out = 1'b0;

    function automatic int to_num(input logic [15:0] v, input int b);
        if (b == 0) return int'(v);
        return int'(v[15:12]) * 1000 + int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [15:0] to_code(input int n, input int b);
        if (b == 0) return n[15:0];
        return {4'((n / 1000) % 10), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
    endfunction

    function automatic logic idle_of(input int md);
        return (md == 1) || (md == 3);
    endfunction

    function automatic logic [15:0] disp_f();
        int full, v;
        full = (m_bcd != 0) ? 10000 : 65536;
        case (m_mode)
            2:       v = (m_N - (m_d % m_N)) % full;
            3:       v = (m_N - ((2 * m_d) % m_N)) % full;
            default: v = (((m_N - m_d) % full) + full) % full;
        endcase
        return to_code(v, m_bcd);
    endfunction

    function automatic logic out_f();
        case (m_mode)
            0:       return m_d >= m_N;
            1:       return m_d < m_N;
            2:       return (m_d % m_N == 0) && (m_d != 0);
            3:       return (m_d % m_N) < ((m_N + 1) / 2);
            default: return m_d == m_N;
        endcase
    endfunction

    always @(posedge clk) begin
        int rise;
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_mode = 0; m_bcd = 0; m_en = 0; m_run = 0; m_N = 65536; m_d = 0;
            m_prev = 0; m_disp = 16'd0; m_out = 1'b0;
        end else begin
            rise = (gate && m_prev == 0) ? 1 : 0;
            m_prev = gate ? 1 : 0;
            if (cfg_wr) begin
                m_mode = (cfg_mode == 3'd6) ? 2 : (cfg_mode == 3'd7) ? 3 : int'(cfg_mode);
                m_bcd = cfg_bcd ? 1 : 0;
                m_en = 1; m_run = 0; m_out = idle_of(m_mode);
            end
            if (load) begin
                m_N = (load_value == 16'd0) ? ((m_bcd != 0) ? 10000 : 65536) : to_num(load_value, m_bcd);
                m_d = 0; m_disp = load_value; m_run = m_en;
                m_out = (m_en != 0) && idle_of(m_mode);
            end else if (m_run != 0 && !cfg_wr && rise != 0 &&
                         (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
                m_d = 0; m_disp = disp_f(); m_out = out_f();
            end else if (m_run != 0 && !cfg_wr && tick && (gate || m_mode == 1 || m_mode == 5)) begin
                m_d = m_d + 1; m_disp = disp_f(); m_out = out_f();
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_cmp = n_cmp + 2;
            if (count !== m_disp) begin
                n_bad++;
                $display("FAIL %s count actual %h expected %h (cycle %0d)", phase, count, m_disp, cycles);
            end
            if (out !== m_out) begin
                n_bad++;
                $display("FAIL %s out actual %b expected %b (cycle %0d)", phase, out, m_out, cycles);
            end
        end
    end

    task automatic drive(input logic t, input logic g, input logic ld, input logic [15:0] v,
                         input logic cw, input logic [2:0] md, input logic b);
        @(negedge clk); #1;
        tick = t; gate = g; load = ld; load_value = v; cfg_wr = cw; cfg_mode = md; cfg_bcd = b;
    endtask

    task automatic step(input logic t, input logic g);
        drive(t, g, 1'b0, load_value, 1'b0, cfg_mode, cfg_bcd);
    endtask

    task automatic run(input int n, input int period, input logic g);
        for (int i = 0; i < n; i++) step((i % period) == 0, g);
    endtask

    task automatic do_cfg(input logic [2:0] md, input logic b);
        drive(1'b0, gate, 1'b0, load_value, 1'b1, md, b);
    endtask

    task automatic do_load(input logic [15:0] v);
        drive(1'b0, gate, 1'b1, v, 1'b0, cfg_mode, cfg_bcd);
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        n_cmp = n_cmp + 1;
        if (count !== 16'd0 || out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset actual %h/%b expected 0000/0", count, out);
        end
        #1 rst_n = 1'b1;
        phase = "R1";
        run(3, 1, 1'b1);
        do_load(16'd5);
        run(4, 1, 1'b1);

        phase = "R7 R6 R4 mode0";
        do_cfg(3'd0, 1'b0); do_load(16'd5);
        run(12, 1, 1'b1); run(4, 1, 1'b0); run(3, 1, 1'b1);

        phase = "R7 R5 mode1";
        do_cfg(3'd1, 1'b0); step(1'b0, 1'b0); do_load(16'd4);
        run(3, 1, 1'b0); step(1'b1, 1'b1); run(8, 1, 1'b1);

        phase = "R8 mode2";
        do_cfg(3'd2, 1'b0); do_load(16'd3);
        run(12, 2, 1'b1);
        do_load(16'd1); run(4, 1, 1'b1);
        do_load(16'd4); run(2, 1, 1'b1); run(2, 1, 1'b0); run(5, 1, 1'b1);

        phase = "R9 mode3";
        do_cfg(3'd3, 1'b0); do_load(16'd6); run(14, 1, 1'b1);
        do_load(16'd5); run(12, 1, 1'b1);
        do_load(16'd1); run(3, 1, 1'b1);
        phase = "R2 code7";
        do_cfg(3'd7, 1'b0); do_load(16'd4); run(6, 1, 1'b1);
        phase = "R2 code6";
        do_cfg(3'd6, 1'b0); do_load(16'd2); run(5, 1, 1'b1);

        phase = "R10 mode4";
        do_cfg(3'd4, 1'b0); do_load(16'd3);
        run(2, 1, 1'b1); run(3, 1, 1'b0); run(4, 1, 1'b1);
        phase = "R10 R5 mode5";
        do_cfg(3'd5, 1'b0); do_load(16'd3);
        run(2, 1, 1'b0); step(1'b1, 1'b1); run(6, 1, 1'b1);

        phase = "R11 bcd";
        do_cfg(3'd0, 1'b1); do_load(16'h0012); run(16, 1, 1'b1);
        do_cfg(3'd3, 1'b1); do_load(16'h0011); run(14, 1, 1'b1);
        do_cfg(3'd1, 1'b1); do_load(16'h0100); run(105, 1, 1'b1);

        phase = "R3 collide";
        do_cfg(3'd2, 1'b0); do_load(16'd5); run(2, 1, 1'b1);
        drive(1'b1, 1'b1, 1'b1, 16'd7, 1'b0, 3'd2, 1'b0);
        run(3, 1, 1'b1);
        drive(1'b0, 1'b1, 1'b1, 16'd9, 1'b1, 3'd4, 1'b0);
        run(11, 1, 1'b1);
        phase = "R5 collide";
        do_cfg(3'd1, 1'b0); do_load(16'd6); run(2, 1, 1'b1); step(1'b1, 1'b0);
        step(1'b1, 1'b1); run(8, 1, 1'b1);
        do_cfg(3'd0, 1'b0); do_load(16'd5); run(2, 1, 1'b1); step(1'b1, 1'b0);
        step(1'b1, 1'b1); run(5, 1, 1'b1);

        phase = "R3 full binary";
        do_cfg(3'd2, 1'b0); do_load(16'd0); run(65540, 1, 1'b1);
        phase = "R3 R11 full bcd";
        do_cfg(3'd0, 1'b1); do_load(16'd0); run(10003, 1, 1'b1);

        @(negedge clk); #1;
        summary();
    end

    initial begin
        wait (cycles > 190000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            summary();
        end
    end
endmodule